// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Saturation Flag

This block computes one saturating arithmetic operation per cycle on two data words and keeps a sticky flag that records whether any qualified operation has clamped since the flag was last cleared. An opcode picks the operation:

- signed add;
- signed add that wraps but still flags;
- signed subtract;
- signed doubling;
- unsigned add;
- unsigned subtract;
- signed clamp to a programmable width;
- unsigned clamp to a programmable width;
- the two width clamps applied independently to both half-word lanes.

The result path is purely combinational from the operand, opcode and width inputs. The flag is a register. It is set at a clock edge when `op_valid` is high and the selected operation clamped, or for the wrapping add, overflowed. No operation can lower it. It returns to zero only on reset or on the synchronous `flag_clear` input.

There is no data handshake. The block accepts an operation in every cycle and never applies back-pressure. `op_valid` qualifies only the flag update, and the result is always driven. Widths below assume the default `DATA_W` of 32. `DATA_W` must be even and at least 4.

Top module: `sat_arith_unit`

## Requirements
- R1: Opcode 0 (signed add) returns the wrapped sum unless both operands share a sign and the sum's sign differs from `opnd_a`. In that case it returns the largest positive value (0x7FFFFFFF) when `opnd_a` is non-negative and the most negative value (0x80000000) otherwise, and counts as a clamp.
- R2: Opcode 1 (flagging add) always returns the wrapped sum, and counts as a clamp exactly when the R1 overflow condition holds.
- R3: Opcode 2 (signed subtract) counts as a clamp when the operands differ in sign and the difference's sign differs from `opnd_a`. It then clamps by the sign of `opnd_a` as in R1, and otherwise returns the wrapped difference.
- R4: Opcode 3 (doubling, `opnd_a` only) returns the largest positive value when `opnd_a` as a signed number is at least one quarter of full scale (0x40000000). It returns the most negative value when `opnd_a` is at or below minus one quarter (0xC0000000), including exactly 0xC0000000. Otherwise it returns `opnd_a` shifted left by one. Both clamps count.
- R5: Opcode 4 (unsigned add) returns all ones when the sum carries out, and opcode 5 (unsigned subtract) returns zero when `opnd_b` exceeds `opnd_a`. Both clamps count, and otherwise the wrapped value is returned.
- R6: Opcode 6 (signed width clamp of `opnd_a`, n = `sat_width`) arithmetic-shifts `opnd_a` right by n. If the shifted value is above zero it returns 2^n-1, if it is below -1 it returns the bitwise inverse of 2^n-1, and otherwise it returns `opnd_a` unchanged. Either clamp counts.
- R7: Opcode 7 (unsigned width clamp, n = `sat_width`) returns 0 for a negative `opnd_a`, returns 2^n-1 when `opnd_a` exceeds 2^n-1, and otherwise returns `opnd_a`. Either clamp counts.
- R8: Opcodes 8 and 9 apply R6 and R7 respectively to each half-word of `opnd_a`, each half taken as a signed lane. Both lanes use the same n, which is the low log2(DATA_W/2) bits of `sat_width`. The low lane result goes in the low half of `result` and the high lane result in the high half. A clamp in either lane counts.
- R9: At a rising clock edge the flag becomes 1 when `op_valid` is high and the operation counts as a clamp, and it holds its value otherwise. `flag_clear` high forces it to 0 at the edge and wins over a simultaneous set.
- R10: While `rst_n` is low the flag is 0.
- R11: Opcodes 10 to 15 return zero and never count as a clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies the flag update for the current operation |
| op_code | input | 4 | Operation select, encodings as in the requirements |
| opnd_a | input | 32 | First operand; the only operand for doubling and clamps |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_width | input | 5 | Width parameter n for the clamp operations |
| flag_clear | input | 1 | Synchronous clear of the sticky flag |
| result | output | 32 | Combinational operation result |
| sticky_flag | output | 1 | Sticky saturation flag |

## Verification
The hardest cases are the isolated edges of each clamp: the exact ±quarter boundary of doubling, and a dual-lane operation where only the high lane clamps. The bench reaches them by running the unit at an 8-bit width and sweeping every operand value, together with every second-operand value or every n, against an arithmetic model. Clamp detection is seen only through the sticky flag. The bench therefore clears the flag, issues a single qualified operation and reads the flag back, on a regular subset of the same sweep.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;
  typedef enum logic [3:0] {
    OP_SADD    = 4'd0,
    OP_SADD_FL = 4'd1,
    OP_SSUB    = 4'd2,
    OP_SDBL    = 4'd3,
    OP_UADD    = 4'd4,
    OP_USUB    = 4'd5,
    OP_SCLAMP  = 4'd6,
    OP_UCLAMP  = 4'd7,
    OP_SCLAMP2 = 4'd8,
    OP_UCLAMP2 = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_addsub.sv
`timescale 1ns/1ps
module sat_addsub
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  sat_op_e      op,
  output logic [W-1:0] res,
  output logic         hit
);
  localparam logic [W-1:0] SMAX    = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN    = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QTR_POS = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] QTR_NEG = {2'b11, {(W-2){1'b0}}};

  logic [W:0]   sum_x, dif_x;
  logic         ovf_add, ovf_sub, dbl_hi, dbl_lo;
  logic [W-1:0] by_sign;

  always_comb begin
    sum_x   = {1'b0, a} + {1'b0, b};
    dif_x   = {1'b0, a} - {1'b0, b};
    ovf_add = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
    ovf_sub = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
    by_sign = a[W-1] ? SMIN : SMAX;
    dbl_hi  = $signed(a) >= $signed(QTR_POS);
    dbl_lo  = $signed(a) <= $signed(QTR_NEG);
    res     = '0;
    hit     = 1'b0;
    case (op)
      OP_SADD: begin
        hit = ovf_add;
        res = ovf_add ? by_sign : sum_x[W-1:0];
      end
      OP_SADD_FL: begin
        hit = ovf_add;
        res = sum_x[W-1:0];
      end
      OP_SSUB: begin
        hit = ovf_sub;
        res = ovf_sub ? by_sign : dif_x[W-1:0];
      end
      OP_SDBL: begin
        hit = dbl_hi || dbl_lo;
        if (dbl_hi)      res = SMAX;
        else if (dbl_lo) res = SMIN;
        else             res = {a[W-2:0], 1'b0};
      end
      OP_UADD: begin
        hit = sum_x[W];
        res = sum_x[W] ? {W{1'b1}} : sum_x[W-1:0];
      end
      OP_USUB: begin
        hit = dif_x[W];
        res = dif_x[W] ? '0 : dif_x[W-1:0];
      end
      default: begin
        res = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sat_lane_clamp.sv
`timescale 1ns/1ps
module sat_lane_clamp #(
  parameter int LW = 32,
  localparam int NW = $clog2(LW)
) (
  input  logic [LW-1:0] val,
  input  logic [NW-1:0] n,
  input  logic          sgn,
  output logic [LW-1:0] res,
  output logic          hit
);
  logic [LW-1:0]        mask;
  logic signed [LW-1:0] top;
  logic                 above, below;

  always_comb begin
    mask  = ~({LW{1'b1}} << n);
    top   = $signed(val) >>> n;
    above = !top[LW-1] && (|top);
    below = top[LW-1] && !(&top);
    res   = val;
    hit   = 1'b0;
    if (sgn) begin
      if (above) begin
        res = mask;
        hit = 1'b1;
      end else if (below) begin
        res = ~mask;
        hit = 1'b1;
      end
    end else begin
      if (val[LW-1]) begin
        res = '0;
        hit = 1'b1;
      end else if (|(val & ~mask)) begin
        res = mask;
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_arith_unit.sv
`timescale 1ns/1ps
module sat_arith_unit
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHW = $clog2(DATA_W),
  localparam int LW  = DATA_W / 2,
  localparam int LNW = $clog2(LW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SHW-1:0]    sat_width,
  input  logic              flag_clear,
  output logic [DATA_W-1:0] result,
  output logic              sticky_flag
);
  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};

  sat_op_e           op;
  logic [DATA_W-1:0] as_res, full_res;
  logic              as_hit, full_hit, any_hit;
  logic [LW-1:0]     lane_res [2];
  logic [1:0]        lane_hit;

  assign op = sat_op_e'(op_code);

  sat_addsub #(.W(DATA_W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .op(op), .res(as_res), .hit(as_hit)
  );

  sat_lane_clamp #(.LW(DATA_W)) u_full (
    .val(opnd_a), .n(sat_width), .sgn(op == OP_SCLAMP),
    .res(full_res), .hit(full_hit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    sat_lane_clamp #(.LW(LW)) u_lane (
      .val(opnd_a[g*LW +: LW]), .n(sat_width[LNW-1:0]),
      .sgn(op == OP_SCLAMP2), .res(lane_res[g]), .hit(lane_hit[g])
    );
  end

  always_comb begin
    case (op)
      OP_SCLAMP, OP_UCLAMP: begin
        result  = full_res;
        any_hit = full_hit;
      end
      OP_SCLAMP2, OP_UCLAMP2: begin
        result  = {lane_res[1], lane_res[0]};
        any_hit = |lane_hit;
      end
      default: begin
        result  = as_res;
        any_hit = as_hit;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sticky_flag <= 1'b0;
    else if (flag_clear)         sticky_flag <= 1'b0;
    else if (op_valid && any_hit) sticky_flag <= 1'b1;
  end

  // Flag register behaviour
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clear |=> !sticky_flag);
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clear && !op_valid) |=> $stable(sticky_flag));
  assert_never_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_flag && !flag_clear) |=> sticky_flag);

  // Result relations at the ports
  assert_usub_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_USUB && opnd_b > opnd_a) |-> result == '0);
  assert_dbl_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_SDBL && !opnd_a[DATA_W-1] && opnd_a[DATA_W-2]) |-> result == SMAX);
  assert_uclamp_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_UCLAMP && opnd_a[DATA_W-1]) |-> result == '0);
  assert_spare_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code >= 4'd10) |-> result == '0);
endmodule

// File: tb/sat_arith_unit_test.sv
`timescale 1ns/1ps
module sat_arith_unit_test;
  localparam int W = 8;
  localparam int LWB = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [3:0]   op_code = '0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [2:0]   sat_width = '0;
  logic         flag_clear = 1'b0;
  logic [W-1:0] result;
  logic         sticky_flag;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sat_arith_unit #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_width(sat_width),
    .flag_clear(flag_clear), .result(result), .sticky_flag(sticky_flag)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (op %0d a %0h b %0h n %0d)",
               tag, act, exp, op_code, opnd_a, opnd_b, sat_width);
    end
  endtask

  function automatic string tag_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6: return "R6";
      7: return "R7";
      8, 9: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic int sx(int v, int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic int clamp_ref(int v, int w, int n, bit sgn, output bit hit);
    int sv, mask, top;
    sv = sx(v, w);
    mask = (1 << n) - 1;
    hit = 1'b0;
    if (sgn) begin
      top = sv >>> n;
      if (top > 0) begin hit = 1'b1; return mask; end
      if (top < -1) begin hit = 1'b1; return (~mask) & ((1 << w) - 1); end
      return v;
    end
    if (sv < 0) begin hit = 1'b1; return 0; end
    if (sv > mask) begin hit = 1'b1; return mask; end
    return v;
  endfunction

  function automatic int model(int op, int a, int b, int n, output bit hit);
    int sa, sb, s, lo, hi;
    bit h0, h1;
    sa = sx(a, W);
    sb = sx(b, W);
    hit = 1'b0;
    case (op)
      0, 1: begin
        s = sa + sb;
        hit = (s > 127) || (s < -128);
        if (op == 0 && hit) return (sa >= 0) ? 8'h7F : 8'h80;
        return s & 8'hFF;
      end
      2: begin
        s = sa - sb;
        hit = (s > 127) || (s < -128);
        if (hit) return (sa >= 0) ? 8'h7F : 8'h80;
        return s & 8'hFF;
      end
      3: begin
        if (sa >= 64) begin hit = 1'b1; return 8'h7F; end
        if (sa <= -64) begin hit = 1'b1; return 8'h80; end
        return (sa * 2) & 8'hFF;
      end
      4: begin
        if (a + b > 255) begin hit = 1'b1; return 8'hFF; end
        return a + b;
      end
      5: begin
        if (b > a) begin hit = 1'b1; return 0; end
        return a - b;
      end
      6, 7: return clamp_ref(a, W, n, op == 6, hit);
      8, 9: begin
        lo = clamp_ref(a & 4'hF, LWB, n & 3, op == 8, h0);
        hi = clamp_ref((a >> 4) & 4'hF, LWB, n & 3, op == 8, h1);
        hit = h0 || h1;
        return (hi << 4) | lo;
      end
      default: return 0;
    endcase
  endfunction

  // Clear, issue one qualified operation, then read the flag back.
  task automatic flag_probe(int op, int a, int b, int n);
    bit h;
    int r;
    @(negedge clk);
    op_valid = 1'b0; flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0; op_valid = 1'b1;
    op_code = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; sat_width = n[2:0];
    r = model(op, a, b, n, h);
    @(negedge clk);
    op_valid = 1'b0;
    check({tag_of(op), " clamp flag"}, int'(sticky_flag), int'(h));
  endtask

  task automatic drive(bit v, bit c, int op, int a, int b, int n);
    @(negedge clk);
    op_valid = v; flag_clear = c;
    op_code = op[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; sat_width = n[2:0];
  endtask

  initial begin
    #(190000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit h;
    int e;
    repeat (3) @(negedge clk);
    check("R10 reset flag", int'(sticky_flag), 0);
    rst_n = 1'b1;

    // Directed flag sequence
    drive(1'b0, 1'b0, 1, 8'h7F, 8'h01, 0);
    @(negedge clk);
    check("R9 invalid op leaves flag", int'(sticky_flag), 0);
    drive(1'b1, 1'b0, 1, 8'h7F, 8'h01, 0);
    @(negedge clk);
    check("R2 flagging add sets flag", int'(sticky_flag), 1);
    check("R2 flagging add wraps", int'(result), 8'h80);
    drive(1'b1, 1'b0, 0, 8'h01, 8'h01, 0);
    @(negedge clk);
    check("R9 clean op keeps flag", int'(sticky_flag), 1);
    drive(1'b0, 1'b1, 0, 0, 0, 0);
    @(negedge clk);
    check("R9 clear", int'(sticky_flag), 0);
    drive(1'b1, 1'b1, 0, 8'h7F, 8'h7F, 0);
    @(negedge clk);
    check("R9 clear beats set", int'(sticky_flag), 0);
    drive(1'b1, 1'b0, 12, 8'hFF, 8'hFF, 7);
    @(negedge clk);
    check("R11 spare op no flag", int'(sticky_flag), 0);
    check("R11 spare op zero", int'(result), 0);
    drive(1'b1, 1'b0, 8, 8'h50, 0, 1);
    @(negedge clk);
    check("R8 high lane alone sets flag", int'(sticky_flag), 1);
    check("R8 high lane alone result", int'(result), 8'h10);
    op_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset clears flag", int'(sticky_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Result sweep: sampled half a step after each change, away from edges
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 256; k++) begin
          if ((op == 3 || op >= 10) && k > 0) break;
          if (op >= 6 && op <= 9 && k > 7) break;
          opnd_a = a[7:0];
          opnd_b = (op >= 6) ? 8'h00 : k[7:0];
          sat_width = (op >= 6 && op <= 9) ? k[2:0] : 3'd0;
          op_code = op[3:0];
          e = model(op, a, int'(opnd_b), int'(sat_width), h);
          #0.5;
          check(tag_of(op), int'(result), e);
          #0.5;
        end
      end
    end

    // Flag sweep on a regular subset
    for (int op = 0; op < 10; op++) begin
      for (int a = 0; a < 256; a += 17) begin
        for (int k = 0; k < 256; k += 17) begin
          if (op == 3 && k > 0) break;
          if (op >= 6) begin
            for (int n = 0; n < 8; n++) flag_probe(op, a, 0, n);
            break;
          end
          flag_probe(op, a, k, 0);
        end
      end
    end
    // Doubling boundaries (R4)
    flag_probe(3, 8'hC0, 0, 0);
    flag_probe(3, 8'hC1, 0, 0);
    flag_probe(3, 8'h3F, 0, 0);
    flag_probe(3, 8'h40, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule